// File: doc/BRIEF.md
# Banked Interrupt Status Controller

This block gathers 137 hardware interrupt sources into five 32-bit banks. Each bank has an enable word and a pending word. A source that goes high sets its pending bit, and that bit stays set until software clears it. The first three banks hold functional sources and the last two hold error sources. Each group drives its own registered interrupt line.

The banks are not all full: banks 2 and 4 implement only their low 24 and 17 bits. A source keeps the number of its bit position, bank × 32 + bit, even when that leaves gaps. For example, bit 0 of bank 3 is source 96. A priority encoder reports the lowest-numbered source that is both pending and enabled, so a handler can go straight to it without scanning the banks.

Software reaches the enable and pending words through a simple synchronous port: a write strobe, a read strobe, a byte address and 32-bit data.

Top module: `irqb_controller`

## Requirements
- R1: After reset every enable and pending bit reads 0, and funcIrq, errIrq, pendValid and pendSrc are all 0.
- R2: Implemented bits per bank are 32, 32, 24, 32 and 17, starting at bit 0. All other bits read 0 and can be set neither by a source nor by a write.
- R3: A pending bit sets on any clock edge at which its source input is high. It stays set after the source falls, until software clears it.
- R4: Writing a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. This works whether or not the bit is enabled.
- R5: If a source is high in the same cycle that its pending bit is written with 1, the bit stays set.
- R6: A source counts as active only when both its pending bit and its enable bit are 1. funcIrq is the registered OR of the active bits of banks 0 to 2, and it changes one clock after the enable or pending state changes.
- R7: errIrq is the registered OR of the active bits of banks 3 and 4. Error sources never drive funcIrq.
- R8: pendSrc gives the lowest-numbered active source, numbered bank × 32 + bit, so lower banks win and lower bits win within a bank. pendValid is 1 exactly when some source is active. When pendValid is 0, pendSrc is 0. Both outputs are registered.
- R9: Byte address 8n is the enable word of bank n, and 8n+4 is its pending word, for n = 0 to 4. An address with bits [1:0] not zero, or a bank index of 5 or more, reads as 0 and ignores writes.
- R10: rdData loads the addressed word on the clock edge at which rdEn is high. It holds its value while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srcIn | input | 160 | Interrupt source inputs; bit bank×32+n feeds bank bit n |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 6 | Byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| funcIrq | output | 1 | Functional interrupt line |
| errIrq | output | 1 | Error interrupt line |
| pendValid | output | 1 | Some enabled source is pending |
| pendSrc | output | 8 | Number of the lowest enabled pending source |

## Verification
First, every source is raised at once. This separates implemented bits from gap bits in both partial banks, and the same check is repeated on the enable words. Next, enables are turned on one at a time, in an order that places an error source, then a bank 2 source, then two bank 0 bits ahead of each other. The reported number moves only if priority runs from bank to bank and then from bit to bit, and only if the gap-preserving numbering is used. Clear masks with mixed ones and zeros, clears of disabled bits, and a clear that lands on a rising source separate write-one-to-clear from plain writes and show that a set beats a clear. Misaligned and out-of-range addresses show that decoding rejects them instead of aliasing them onto a real bank.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int NUM_BANKS  = 5;
  localparam int FUNC_BANKS = 3;
  localparam int BANK_W     = 32;
  localparam int NUM_SRC    = NUM_BANKS * BANK_W;
  localparam int SRC_W      = $clog2(NUM_SRC);
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);
  localparam int ADDR_W     = BANK_IDX_W + 3;

  typedef struct packed {
    logic                  ctrlWr;
    logic                  statWr;
    logic                  rdStb;
    logic                  rdHit;
    logic                  rdStat;
    logic [BANK_IDX_W-1:0] bank;
  } strobe_t;

  // Number of implemented bits in each bank (filled from bit 0 upward)
  function automatic int bankWidth(input int b);
    case (b)
      2:       return 24;
      4:       return 17;
      default: return 32;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] implMask(input int b);
    logic [63:0] m;
    m = (64'd1 << bankWidth(b)) - 64'd1;
    return m[BANK_W-1:0];
  endfunction

  function automatic logic isImpl(input logic [SRC_W-1:0] src);
    return int'(src % BANK_W) < bankWidth(int'(src / BANK_W));
  endfunction
endpackage

// File: rtl/irqb_ctrl.sv
module irqb_ctrl
  import irqb_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  logic [ADDR_W-4:0] bankField;
  logic              hit;

  assign bankField = addr[ADDR_W-1:3];
  assign hit = (addr[1:0] == 2'b00) && (int'(bankField) < NUM_BANKS);

  always_comb begin
    stb        = '0;
    stb.bank   = BANK_IDX_W'(bankField);
    stb.rdStat = addr[2];
    stb.rdHit  = hit;
    stb.rdStb  = rdEn;
    stb.ctrlWr = wrEn && hit && !addr[2];
    stb.statWr = wrEn && hit && addr[2];
  end
endmodule

// File: rtl/irqb_datapath.sv
module irqb_datapath
  import irqb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            stb,
  input  logic [BANK_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [BANK_W-1:0]  rdData,
  output logic               funcIrq,
  output logic               errIrq,
  output logic               pendValid,
  output logic [SRC_W-1:0]   pendSrc
);
  localparam int FUNC_TOP = FUNC_BANKS * BANK_W;

  logic [BANK_W-1:0]  ctrlQ [NUM_BANKS];
  logic [BANK_W-1:0]  statQ [NUM_BANKS];
  logic [NUM_SRC-1:0] activeVec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              selThis;
    logic [BANK_W-1:0] clrMask;
    assign selThis = (stb.bank == BANK_IDX_W'(b));
    assign clrMask = (stb.statWr && selThis) ? wrData : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrlQ[b] <= '0;
        statQ[b] <= '0;
      end else begin
        if (stb.ctrlWr && selThis) ctrlQ[b] <= wrData & implMask(b);
        // rising source beats a same-cycle clear
        statQ[b] <= (statQ[b] & ~clrMask) | (srcIn[b*BANK_W +: BANK_W] & implMask(b));
      end
    end

    assign activeVec[b*BANK_W +: BANK_W] = statQ[b] & ctrlQ[b];
  end

  // lowest active index wins: scan downward so the last hit is the lowest
  logic [SRC_W-1:0] firstIdx;
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (activeVec[i]) firstIdx = SRC_W'(i);
    end
  end

  logic [BANK_W-1:0] rdMux;
  always_comb begin
    rdMux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (stb.rdHit && stb.bank == BANK_IDX_W'(b))
        rdMux = stb.rdStat ? statQ[b] : ctrlQ[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData    <= '0;
      funcIrq   <= 1'b0;
      errIrq    <= 1'b0;
      pendValid <= 1'b0;
      pendSrc   <= '0;
    end else begin
      if (stb.rdStb) rdData <= rdMux;
      funcIrq   <= |activeVec[FUNC_TOP-1:0];
      errIrq    <= |activeVec[NUM_SRC-1:FUNC_TOP];
      pendValid <= |activeVec;
      pendSrc   <= firstIdx;
    end
  end
endmodule

// File: rtl/irqb_controller.sv
module irqb_controller
  import irqb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BANK_W-1:0]  wrData,
  output logic [BANK_W-1:0]  rdData,
  output logic               funcIrq,
  output logic               errIrq,
  output logic               pendValid,
  output logic [SRC_W-1:0]   pendSrc
);
  strobe_t stb;

  irqb_ctrl u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .stb  (stb)
  );

  irqb_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .wrData    (wrData),
    .srcIn     (srcIn),
    .rdData    (rdData),
    .funcIrq   (funcIrq),
    .errIrq    (errIrq),
    .pendValid (pendValid),
    .pendSrc   (pendSrc)
  );
endmodule

// File: rtl/irqb_chk.sv
module irqb_chk
  import irqb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] rdData,
  input logic              funcIrq,
  input logic              errIrq,
  input logic              pendValid,
  input logic [SRC_W-1:0]  pendSrc
);
  localparam int FUNC_TOP = FUNC_BANKS * BANK_W;

  logic badAddr;
  assign badAddr = (addr[1:0] != 2'b00) || (int'(addr[ADDR_W-1:3]) >= NUM_BANKS);

  // R8
  idle_src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pendValid |-> pendSrc == '0);

  // R8
  valid_matches_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pendValid == (funcIrq || errIrq));

  // R6
  func_src_raises_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendValid && int'(pendSrc) < FUNC_TOP) |-> funcIrq);

  // R7
  err_src_only_when_no_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendValid && int'(pendSrc) >= FUNC_TOP) |-> (errIrq && !funcIrq));

  // R2
  no_gap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pendValid |-> isImpl(pendSrc));

  // R9
  bad_addr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && badAddr) |=> rdData == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdEn && $past(rst_n)) |=> $stable(rdData));
endmodule

bind irqb_controller irqb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rdEn      (rdEn),
  .addr      (addr),
  .rdData    (rdData),
  .funcIrq   (funcIrq),
  .errIrq    (errIrq),
  .pendValid (pendValid),
  .pendSrc   (pendSrc)
);

// File: tb/sim_irqb_controller.sv
`timescale 1ns/1ps
module sim_irqb_controller;
  import irqb_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC-1:0] srcIn = '0;
  logic               wrEn = 1'b0;
  logic               rdEn = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [BANK_W-1:0]  wrData = '0;
  logic [BANK_W-1:0]  rdData;
  logic               funcIrq, errIrq, pendValid;
  logic [SRC_W-1:0]   pendSrc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqb_controller u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  // one more edge so the registered outputs follow the register state
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic checkLines(input string req, input logic f, input logic e,
                            input logic v, input int s);
    check({req, " funcIrq"}, 32'(funcIrq), 32'(f));
    check({req, " errIrq"}, 32'(errIrq), 32'(e));
    check({req, " pendValid"}, 32'(pendValid), 32'(v));
    check({req, " pendSrc"}, 32'(pendSrc), 32'(s));
  endtask

  task automatic testReset();
    logic [31:0] d;
    checkLines("R1", 0, 0, 0, 0);
    for (int n = 0; n < NUM_BANKS; n++) begin
      doRead(ADDR_W'(8*n), d);     check("R1 enable", d, 0);
      doRead(ADDR_W'(8*n + 4), d); check("R1 pending", d, 0);
    end
  endtask

  task automatic testLatchAndGaps();
    logic [31:0] d;
    srcIn = '1;
    @(negedge clk);
    srcIn = '0;
    doRead(6'h04, d); check("R3 bank0 latched", d, 32'hFFFF_FFFF);
    doRead(6'h14, d); check("R2 bank2 gaps", d, 32'h00FF_FFFF);
    doRead(6'h24, d); check("R2 bank4 gaps", d, 32'h0001_FFFF);
    doWrite(6'h10, 32'hFFFF_FFFF);
    doRead(6'h10, d); check("R2 enable gaps", d, 32'h00FF_FFFF);
    settle();
    checkLines("R6 bank2 enabled", 1, 0, 1, 64);
    doWrite(6'h10, 32'h0);
    settle();
    checkLines("R6 masked", 0, 0, 0, 0);
  endtask

  task automatic testPriority();
    doWrite(6'h18, 32'h1);
    settle();
    checkLines("R7 error source", 0, 1, 1, 96);
    doWrite(6'h20, 32'h0001_0000);
    settle();
    checkLines("R8 keeps 96", 0, 1, 1, 96);
    doWrite(6'h10, 32'h20);
    settle();
    checkLines("R8 bank2 first", 1, 1, 1, 69);
    doWrite(6'h00, 32'h8000_0008);
    settle();
    checkLines("R8 lowest bit", 1, 1, 1, 3);
  endtask

  task automatic testClear();
    logic [31:0] d;
    doWrite(6'h04, 32'h8);
    doRead(6'h04, d); check("R4 one bit cleared", d, 32'hFFFF_FFF7);
    settle();
    checkLines("R4 next source", 1, 1, 1, 31);
    doWrite(6'h04, 32'h0);
    doRead(6'h04, d); check("R4 zeros keep", d, 32'hFFFF_FFF7);
    doWrite(6'h0C, 32'hFFFF_FFFF);
    doRead(6'h0C, d); check("R4 disabled cleared", d, 32'h0);
  endtask

  task automatic testSetWins();
    logic [31:0] d;
    srcIn[40] = 1'b1;
    doWrite(6'h0C, 32'h100);
    srcIn[40] = 1'b0;
    doRead(6'h0C, d); check("R5 set beats clear", d, 32'h100);
    doWrite(6'h0C, 32'h100);
    doRead(6'h0C, d); check("R3 cleared later", d, 32'h0);
  endtask

  task automatic testAllClear();
    for (int n = 0; n < NUM_BANKS; n++) doWrite(ADDR_W'(8*n + 4), 32'hFFFF_FFFF);
    settle();
    checkLines("R8 nothing active", 0, 0, 0, 0);
  endtask

  task automatic testAddress();
    logic [31:0] d;
    doWrite(6'h01, 32'h55);
    doRead(6'h00, d); check("R9 misaligned write ignored", d, 32'h8000_0008);
    doRead(6'h28, d); check("R9 bank5 reads zero", d, 0);
    doRead(6'h3C, d); check("R9 high offset reads zero", d, 0);
    doRead(6'h02, d); check("R9 misaligned read zero", d, 0);
    doRead(6'h00, d);
    addr = 6'h20;
    @(negedge clk);
    @(negedge clk);
    check("R10 holds without rdEn", rdData, 32'h8000_0008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testLatchAndGaps();
    testPriority();
    testClear();
    testSetWins();
    testAllClear();
    testAddress();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule